// File: doc/BRIEF.md
# Phase-Slope Limiter for a Digital PLL

The block sits in the error path of a digital phase-locked loop, between the phase comparator and the loop filter. Each time the comparator presents a new phase-error word with an update strobe, the block bounds that word to a fixed per-update step and sends the result on to the filter. The error is a signed two's-complement count of a fixed time quantum. With the default quantum of 125 ps, the default step of 40 counts equals 5 ns. At an 8 kHz update rate this keeps the recovered phase within 5 ns per 125 µs, whatever transient reaches the input. That is tighter than the 7.6 ns per 125 µs slope that telecom timing rules allow.

A fast-lock input is sampled with each strobe. When it is high, the bound is not applied for that update and the error goes through unchanged. This lets the loop pull in within its 500 ms acquisition budget. Every result is registered and comes with a one-cycle valid pulse. A sticky flag records that a bound was applied. A one-cycle clear pulse resets the flag.

A two-state sequencer paces the output. In `ST_WAIT` the output is not valid. A strobe takes the sequencer through `WAIT_TO_SEND` into `ST_SEND`, and the output register loads on that same edge. In `ST_SEND` the valid output is high. A further strobe keeps the sequencer in `ST_SEND` through `SEND_HOLD`, for back-to-back updates. A cycle with no strobe returns it to `ST_WAIT` through `SEND_TO_WAIT`. With no strobe in `ST_WAIT`, it stays there through `WAIT_IDLE`.

Top module: `phase_slope_limiter`

## Requirements
- R1: After reset, `res_valid` is 0, `res_err` is 0 and `clamp_seen` is 0.
- R2: `res_valid` is high in the cycle after each cycle in which `upd_stb` is high, and it is low in every other cycle. There is exactly one valid cycle per strobe cycle, including back-to-back strobes.
- R3: In normal mode (`fast_lock` = 0), an error greater than +STEP_LIM produces `res_err` = +STEP_LIM.
- R4: In normal mode, an error less than −STEP_LIM produces `res_err` = −STEP_LIM. This includes the most negative code (−2^(ERR_W−1)), which must not wrap.
- R5: In normal mode, an error in the range −STEP_LIM to +STEP_LIM inclusive passes to `res_err` unchanged.
- R6: With `fast_lock` = 1 at the strobe, any error, including values outside the limit, passes to `res_err` unchanged.
- R7: `clamp_seen` goes high in the cycle after a normal-mode strobe whose error lies outside ±STEP_LIM. An in-range error or a fast-lock strobe leaves it unchanged.
- R8: A one-cycle `clamp_clr` pulse drives `clamp_seen` low in the next cycle. If a clamping strobe arrives in the same cycle as the clear, the flag stays set.
- R9: `res_err` holds its last value in cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_stb | input | 1 | Update strobe marking a new phase error |
| upd_err | input | ERR_W | Signed phase error in time quanta |
| fast_lock | input | 1 | 1 = bypass the bound for this update |
| clamp_clr | input | 1 | Clear pulse for the sticky flag |
| res_valid | output | 1 | One-cycle valid for the result |
| res_err | output | ERR_W | Bounded (or bypassed) signed error |
| clamp_seen | output | 1 | Sticky flag: a bound was applied |

## Verification
The assertions rely on certain properties of the inputs. `upd_err` and `fast_lock` must be known and settled at every edge where `upd_stb` is high. `clamp_clr` must be a clean level sampled on the clock, and STEP_LIM must be positive and below 2^(ERR_W−1). The bench meets these conditions by changing every input only on the falling clock edge. It also keeps the default parameters, so the bound stays representable. Its stimulus includes isolated strobes, back-to-back strobes and a clear pulse that coincides with a clamping strobe. The error words include both extreme codes, the values one step either side of each limit, and the limits themselves.

// File: rtl/psl_pkg.sv
package psl_pkg;

    // Output sequencer states
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_SEND = 1'b1
    } psl_state_e;

    // Decision taken for one update
    typedef enum logic [1:0] {
        DEC_PASS   = 2'd0,
        DEC_CAP_HI = 2'd1,
        DEC_CAP_LO = 2'd2,
        DEC_BYPASS = 2'd3
    } psl_dec_e;

endpackage

// File: rtl/psl_clamp.sv
module psl_clamp
    import psl_pkg::*;
#(
    parameter int ERR_W    = 16,
    parameter int STEP_LIM = 40
) (
    input  logic signed [ERR_W-1:0] err_in,
    input  logic                    bypass,
    output logic signed [ERR_W-1:0] err_out,
    output psl_dec_e                decision
);

    localparam logic signed [ERR_W-1:0] POS_LIM = ERR_W'(STEP_LIM);
    localparam logic signed [ERR_W-1:0] NEG_LIM = ERR_W'(-STEP_LIM);

    logic above;
    logic below;

    // Signed comparisons against constants; the result is always a
    // representable value, so the most negative code cannot wrap.
    assign above = (err_in > POS_LIM);
    assign below = (err_in < NEG_LIM);

    always_comb begin
        if (bypass) begin
            decision = DEC_BYPASS;
        end else if (above) begin
            decision = DEC_CAP_HI;
        end else if (below) begin
            decision = DEC_CAP_LO;
        end else begin
            decision = DEC_PASS;
        end
    end

    always_comb begin
        unique case (decision)
            DEC_CAP_HI: err_out = POS_LIM;
            DEC_CAP_LO: err_out = NEG_LIM;
            DEC_BYPASS: err_out = err_in;
            default:    err_out = err_in;
        endcase
    end

endmodule

// File: rtl/psl_seq.sv
module psl_seq
    import psl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic load,
    output logic valid
);

    psl_state_e state_q;
    psl_state_e state_d;

    // Next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (strobe) state_d = ST_SEND;   // WAIT_TO_SEND
                else        state_d = ST_WAIT;   // WAIT_IDLE
            end
            ST_SEND: begin
                if (strobe) state_d = ST_SEND;   // SEND_HOLD
                else        state_d = ST_WAIT;   // SEND_TO_WAIT
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load  = strobe;
        valid = 1'b0;
        unique case (state_q)
            ST_WAIT: valid = 1'b0;
            ST_SEND: valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !valid);

endmodule

// File: rtl/psl_sticky.sv
module psl_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;   // a new event beats the clear
        else if (clr_evt) flag <= 1'b0;
    end

    a_r7_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_evt && !set_evt) |=> $stable(flag));

endmodule

// File: rtl/phase_slope_limiter.sv
module phase_slope_limiter
    import psl_pkg::*;
#(
    parameter int ERR_W    = 16,
    parameter int STEP_LIM = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_stb,
    input  logic signed [ERR_W-1:0] upd_err,
    input  logic                    fast_lock,
    input  logic                    clamp_clr,
    output logic                    res_valid,
    output logic signed [ERR_W-1:0] res_err,
    output logic                    clamp_seen
);

    localparam logic signed [ERR_W-1:0] POS_LIM = ERR_W'(STEP_LIM);
    localparam logic signed [ERR_W-1:0] NEG_LIM = ERR_W'(-STEP_LIM);

    logic signed [ERR_W-1:0] bounded;
    psl_dec_e                decision;
    logic                    load;
    logic                    capped;
    logic signed [ERR_W-1:0] res_q;

    psl_clamp #(
        .ERR_W    (ERR_W),
        .STEP_LIM (STEP_LIM)
    ) u_clamp (
        .err_in   (upd_err),
        .bypass   (fast_lock),
        .err_out  (bounded),
        .decision (decision)
    );

    psl_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (upd_stb),
        .load   (load),
        .valid  (res_valid)
    );

    assign capped = upd_stb && ((decision == DEC_CAP_HI) || (decision == DEC_CAP_LO));

    psl_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (capped),
        .clr_evt (clamp_clr),
        .flag    (clamp_seen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    res_q <= '0;
        else if (load) res_q <= bounded;
    end

    assign res_err = res_q;

    a_r3_cap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !fast_lock && (upd_err > POS_LIM)) |=> (res_err == POS_LIM));
    a_r4_cap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !fast_lock && (upd_err < NEG_LIM)) |=> (res_err == NEG_LIM));
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !fast_lock && (upd_err <= POS_LIM) && (upd_err >= NEG_LIM))
        |=> (res_err == $past(upd_err)));
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && fast_lock) |=> (res_err == $past(upd_err)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> $stable(res_err));
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(fast_lock)) |-> ((res_err <= POS_LIM) && (res_err >= NEG_LIM)));

endmodule

// File: tb/phase_slope_limiter_tb.sv
module phase_slope_limiter_tb;

    localparam int W   = 16;
    localparam int LIM = 40;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                upd_stb = 1'b0;
    logic signed [W-1:0] upd_err = '0;
    logic                fast_lock = 1'b0;
    logic                clamp_clr = 1'b0;
    logic                res_valid;
    logic signed [W-1:0] res_err;
    logic                clamp_seen;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic signed [W-1:0] exp_q[$];
    string               tag_q[$];

    always #4 clk = ~clk;

    phase_slope_limiter #(.ERR_W(W), .STEP_LIM(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .upd_err(upd_err),
        .fast_lock(fast_lock), .clamp_clr(clamp_clr),
        .res_valid(res_valid), .res_err(res_err), .clamp_seen(clamp_seen)
    );

    function automatic logic signed [W-1:0] model(logic signed [W-1:0] v, logic fl);
        if (fl) return v;
        if (v > LIM) return W'(LIM);
        if (v < -LIM) return W'(-LIM);
        return v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: one strobe; leaves strobe high when back-to-back follows
    task automatic send(logic signed [W-1:0] v, logic fl, string req, bit keep);
        @(negedge clk);
        upd_stb = 1'b1; upd_err = v; fast_lock = fl;
        exp_q.push_back(model(v, fl));
        tag_q.push_back(req);
        if (!keep) begin
            @(negedge clk);
            upd_stb = 1'b0;
        end
    endtask

    // Monitor: compares each valid result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 spurious valid", 1, 0);
            end else begin
                logic signed [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_err == e, t, res_err, e);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 valid", res_valid, 0);
        check(res_err == 0, "R1 data", res_err, 0);
        check(clamp_seen == 1'b0, "R1 flag", clamp_seen, 0);
        rst_n = 1'b1;

        // R5 in-range values, including both limits
        send(16'sd0, 1'b0, "R5 zero", 1'b0);
        send(16'sd40, 1'b0, "R5 +limit", 1'b0);
        send(-16'sd40, 1'b0, "R5 -limit", 1'b0);
        send(-16'sd39, 1'b0, "R5 inside", 1'b0);
        @(negedge clk);
        check(clamp_seen == 1'b0, "R7 no set in range", clamp_seen, 0);

        // R9 hold between strobes
        send(16'sd17, 1'b0, "R5 mid", 1'b0);
        repeat (3) @(negedge clk);
        check(res_err == 16'sd17, "R9 hold", res_err, 17);
        check(res_valid == 1'b0, "R2 idle low", res_valid, 0);

        // R6 bypass with out-of-range values: flag must stay low
        send(16'sd1000, 1'b1, "R6 bypass high", 1'b0);
        send(-16'sd32768, 1'b1, "R6 bypass min", 1'b0);
        @(negedge clk);
        check(clamp_seen == 1'b0, "R7 no set in bypass", clamp_seen, 0);

        // R3 and R4 clamping
        send(16'sd41, 1'b0, "R3 just above", 1'b0);
        @(negedge clk);
        check(clamp_seen == 1'b1, "R7 set on clamp", clamp_seen, 1);
        send(16'sd32767, 1'b0, "R3 max code", 1'b0);
        send(-16'sd41, 1'b0, "R4 just below", 1'b0);
        send(-16'sd32768, 1'b0, "R4 min code", 1'b0);

        // R8 clear
        @(negedge clk);
        clamp_clr = 1'b1;
        @(negedge clk);
        clamp_clr = 1'b0;
        check(clamp_seen == 1'b0, "R8 cleared", clamp_seen, 0);

        // R8 clear coinciding with clamping strobe: set wins
        @(negedge clk);
        clamp_clr = 1'b1;
        upd_stb = 1'b1; upd_err = 16'sd500; fast_lock = 1'b0;
        exp_q.push_back(model(16'sd500, 1'b0));
        tag_q.push_back("R3 with clear");
        @(negedge clk);
        clamp_clr = 1'b0; upd_stb = 1'b0;
        check(clamp_seen == 1'b1, "R8 set beats clear", clamp_seen, 1);

        // R2 back-to-back strobes, mixed modes
        send(16'sd100, 1'b0, "R2 b2b a", 1'b1);
        send(-16'sd7, 1'b0, "R2 b2b b", 1'b1);
        send(-16'sd300, 1'b1, "R2 b2b c", 1'b1);
        send(-16'sd300, 1'b0, "R2 b2b d", 1'b0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule